// File: doc/BRIEF.md
# Strobed FIFO with retransmit

This block is a queue of 9-bit words filled and drained through two active-low strobes, one for the writer and one for the reader. Each strobe may be driven by logic with no relation to the system clock. The block passes both strobes through synchronisers, finds their edges in the system clock and commits a write on the rising edge of the write strobe and a read on the falling edge of the read strobe. Three active-low flags report the fill level: empty, full and more-than-half-full. The storage depth is a power-of-two parameter.

A third active-low strobe, retransmit, rewinds the read position to the first storage location without moving the write position. The words written since reset can then be read a second time, and all flags are recomputed from the new occupancy. When the mode input is high the block is one member of a chain of queues: retransmit is ignored and the half-full flag stays inactive. The write data must stay stable from the write-strobe rising edge until the commit three clock edges later. Retransmit is pulsed only while both data strobes are idle.

Top module: `strobed_fifo`

## Requirements
- R1: A low `rst_n` sampled on a clock edge sets read and write positions to location 0, occupancy to 0, `empty_n` to 0, `full_n` to 1, `half_n` to 1 and `dout` to 0.
- R2: A rising edge of `wr_n` stores `din` at the tail when occupancy is below DEPTH; a write edge while DEPTH words are held is dropped and changes no word and no flag.
- R3: A falling edge of `rd_n` moves the oldest word to `dout` when occupancy is nonzero; a read edge on an empty queue is dropped and `dout` keeps its value.
- R4: `full_n` goes low at the falling edge of `wr_n` that begins the write bringing occupancy from DEPTH-1 to DEPTH, and goes high at the next rising edge of `rd_n`, not at its falling edge.
- R5: `empty_n` goes low at the falling edge of `rd_n` that takes the last word and goes high at the `wr_n` rising edge that commits a word into an empty queue.
- R6: In single-queue mode (`expand_mode` = 0) `half_n` is 0 exactly when occupancy exceeds DEPTH/2.
- R7: In single-queue mode a low pulse on `rexmit_n`, acting at its rising edge, sets the read position to location 0, keeps the write position, sets occupancy to the number of words written since reset (DEPTH once the write position has wrapped) and recomputes all three flags.
- R8: With `expand_mode` = 1 a `rexmit_n` pulse leaves the read position unchanged and `half_n` stays 1; `full_n` and `empty_n` work as in R4 and R5.
- R9: A word written into an empty queue can be read at once: `empty_n` rises after the write, and the next read returns that word and drives `empty_n` low again.
- R10: Every strobe edge takes effect on the third rising clock edge after it reaches the pin, and a strobe held low for many cycles counts as one action.
- R11: `dout` changes only on an accepted read; writes, dropped reads and retransmit leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| expand_mode | input | 1 | 1 = chained member, retransmit and half-full disabled |
| wr_n | input | 1 | Active-low write strobe, commits on its rising edge |
| rd_n | input | 1 | Active-low read strobe, reads on its falling edge |
| rexmit_n | input | 1 | Active-low retransmit strobe |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| full_n | output | 1 | Active-low full flag |
| empty_n | output | 1 | Active-low empty flag |
| half_n | output | 1 | Active-low more-than-half-full flag |

## Verification
Every result is due on the third rising clock edge after the strobe edge that causes it: two synchroniser flops, then the register that holds occupancy, flags, pointers and `dout`. The bench changes strobes on falling clock edges and samples five falling edges later, well after the update. The full and empty flags tied to the opening edge of a strobe are sampled while that strobe is still low. The latency check samples once after the second rising edge, where nothing may have moved yet, and once after the third, where the flag must have changed.

// File: rtl/sfifo_pkg.sv
// Shared constants and types for the strobed FIFO.
// Assumes a 9-bit word and three strobes (write, read, retransmit).
package sfifo_pkg;
    localparam int WORD_W      = 9;
    localparam int NUM_STROBES = 3;
    localparam int IDX_WR      = 0;
    localparam int IDX_RD      = 1;
    localparam int IDX_RT      = 2;

    // One-cycle pulses marking edges of a synchronised strobe.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/sfifo_strobe_sync.sv
// Brings one active-low strobe into the clock domain and flags its edges.
// Assumes the strobe idles high; reset loads the chain with ones so no
// false edge appears after reset. Edges are valid after STAGES clock edges.
module sfifo_strobe_sync
    import sfifo_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_n,
    output edge_t ev
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    // Purpose: shift the raw strobe through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], strobe_n};
        end
    end

    // Purpose: decode one-cycle edge pulses from level and history.
    always_comb begin
        ev.rise = chain[STAGES-1] & ~chain[STAGES];
        ev.fall = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/sfifo_ctrl.sv
// Pointer, occupancy and flag control for the strobed FIFO.
// Assumes DEPTH is a power of two of at least 4, and that retransmit is
// pulsed only while the data strobes are idle (it takes priority).
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expand_mode,
    input  edge_t         wr_ev,
    input  edge_t         rd_ev,
    input  edge_t         rt_ev,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] occ,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_n
);
    localparam logic [CW-1:0] CNT_FULL   = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_LAST   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_HALF   = CW'(DEPTH / 2);
    localparam logic [AW-1:0] ADDR_TOP   = AW'(DEPTH - 1);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          wrapped;
    logic          rt_armed;
    logic          rt_go;
    logic          wr_go;
    logic          rd_go;
    logic [CW-1:0] occ_rt;
    logic [CW-1:0] occ_nxt;
    logic          full_n_nxt;
    logic          empty_n_nxt;

    // Purpose: decide which strobe actions are accepted this cycle.
    always_comb begin
        rt_go = rt_ev.rise && rt_armed && !expand_mode;
        wr_go = wr_ev.rise && (occ != CNT_FULL) && !rt_go;
        rd_go = rd_ev.fall && (occ != '0) && !rt_go;
    end

    // Purpose: occupancy seen after a rewind is everything written since reset.
    always_comb begin
        occ_rt = wrapped ? CNT_FULL : CW'(wr_ptr);
    end

    // Purpose: next occupancy from accepted actions.
    always_comb begin
        if (rt_go) begin
            occ_nxt = occ_rt;
        end else begin
            occ_nxt = occ + CW'(wr_go) - CW'(rd_go);
        end
    end

    // Purpose: full flag follows write-fall (assert) and read-rise (release).
    always_comb begin
        full_n_nxt = full_n;
        if (rt_go) begin
            full_n_nxt = (occ_nxt != CNT_FULL);
        end else if (wr_ev.fall && occ == CNT_LAST) begin
            full_n_nxt = 1'b0;
        end else if (rd_ev.rise && occ != CNT_FULL) begin
            full_n_nxt = 1'b1;
        end
    end

    // Purpose: empty flag follows read-fall (assert) and write-rise (release).
    always_comb begin
        empty_n_nxt = empty_n;
        if (rt_go) begin
            empty_n_nxt = (occ_nxt != '0);
        end else if (rd_go && !wr_go && occ == CW'(1)) begin
            empty_n_nxt = 1'b0;
        end else if (wr_go) begin
            empty_n_nxt = 1'b1;
        end
    end

    // Purpose: update pointers, wrap marker and retransmit arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            wrapped  <= 1'b0;
            rt_armed <= 1'b0;
        end else begin
            if (wr_go) begin
                wr_ptr <= wr_ptr + AW'(1);
                if (wr_ptr == ADDR_TOP) begin
                    wrapped <= 1'b1;
                end
            end
            if (rt_go) begin
                rd_ptr <= '0;
            end else if (rd_go) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            if (rt_ev.fall) begin
                rt_armed <= 1'b1;
            end else if (rt_ev.rise) begin
                rt_armed <= 1'b0;
            end
        end
    end

    // Purpose: register occupancy and the three flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ     <= '0;
            full_n  <= 1'b1;
            empty_n <= 1'b0;
            half_n  <= 1'b1;
        end else begin
            occ     <= occ_nxt;
            full_n  <= full_n_nxt;
            empty_n <= empty_n_nxt;
            half_n  <= expand_mode || (occ_nxt <= CNT_HALF);
        end
    end

    assign wr_en   = wr_go;
    assign wr_addr = wr_ptr;
    assign rd_en   = rd_go;
    assign rd_addr = rd_ptr;
endmodule

// File: rtl/sfifo_store.sv
// Word storage with a registered read port for the strobed FIFO.
// Assumes the controller never reads and writes one address in one cycle.
module sfifo_store #(
    parameter  int DEPTH = 16,
    parameter  int W     = 9,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  din,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  dout
);
    logic [W-1:0] cells [DEPTH];

    // Purpose: write an accepted word into its cell.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= din;
        end
    end

    // Purpose: load the output register on an accepted read only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (rd_en) begin
            dout <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/strobed_fifo.sv
// Top of the strobed FIFO: synchronises the three strobes, then drives
// the controller and storage. Assumes din is stable from the write-strobe
// rising edge until the commit SYNC_STAGES+1 clock edges later.
module strobed_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expand_mode,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rexmit_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NUM_STROBES-1:0] strobes_n;
    edge_t                  ev [NUM_STROBES];
    logic                   wr_en;
    logic                   rd_en;
    logic [AW-1:0]          wr_addr;
    logic [AW-1:0]          rd_addr;
    logic [CW-1:0]          occ;

    assign strobes_n[IDX_WR] = wr_n;
    assign strobes_n[IDX_RD] = rd_n;
    assign strobes_n[IDX_RT] = rexmit_n;

    // One synchroniser and edge detector per strobe.
    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
        sfifo_strobe_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobes_n[g]),
            .ev       (ev[g])
        );
    end

    sfifo_ctrl #(
        .DEPTH(DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .expand_mode (expand_mode),
        .wr_ev       (ev[IDX_WR]),
        .rd_ev       (ev[IDX_RD]),
        .rt_ev       (ev[IDX_RT]),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .occ         (occ),
        .full_n      (full_n),
        .empty_n     (empty_n),
        .half_n      (half_n)
    );

    sfifo_store #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .din     (din),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .dout    (dout)
    );
endmodule

// File: rtl/sfifo_checker.sv
// Property checker for the strobed FIFO, bound to every strobed_fifo.
// Assumes expand_mode changes only while rst_n is low.
module sfifo_checker #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          expand_mode,
    input logic          wr_rise,
    input logic          rd_fall,
    input logic          rt_rise,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [CW-1:0] occ,
    input logic [8:0]    dout,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_n
);
    p_reset_flags_r1: assert property (@(posedge clk)
        !rst_n |=> (full_n && !empty_n && half_n && dout == '0));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && wr_rise && !rd_fall && !rt_rise) |=> occ == CW'(DEPTH));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && rd_fall && !wr_rise && !rt_rise) |=> (occ == '0 && $stable(dout)));

    p_full_at_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ == CW'(DEPTH) |-> !full_n);

    p_empty_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_n == (occ != '0));

    p_half_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !expand_mode |-> (half_n == (occ <= CW'(DEPTH / 2))));

    p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_rise && !expand_mode) |=> rd_addr == '0);

    p_mode_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expand_mode |-> half_n);

    p_dout_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout));
endmodule

bind strobed_fifo sfifo_checker #(
    .DEPTH(DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .expand_mode (expand_mode),
    .wr_rise     (ev[0].rise),
    .rd_fall     (ev[1].fall),
    .rt_rise     (ev[2].rise),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .occ         (occ),
    .dout        (dout),
    .full_n      (full_n),
    .empty_n     (empty_n),
    .half_n      (half_n)
);

// File: tb/sim_strobed_fifo.sv
// Self-checking bench for strobed_fifo: a vector table walked by one loop,
// then directed tests for latency, long pulses, flag edges, modes and reset.
module sim_strobed_fifo;
    localparam int DEPTH    = 8;
    localparam int SETTLE   = 5;
    localparam int WATCHDOG = 150000;
    localparam int NVEC     = 25;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_RT = 2'd2;

    // {op, din, expected dout, expected {empty_n, full_n, half_n}}
    localparam logic [22:0] VEC [NVEC] = '{
        {OP_WR, 9'h101, 9'h000, 3'b111},
        {OP_RD, 9'h000, 9'h101, 3'b011},
        {OP_WR, 9'h0A5, 9'h101, 3'b111},
        {OP_WR, 9'h1FF, 9'h101, 3'b111},
        {OP_WR, 9'h003, 9'h101, 3'b111},
        {OP_WR, 9'h044, 9'h101, 3'b111},
        {OP_WR, 9'h155, 9'h101, 3'b110},
        {OP_RD, 9'h000, 9'h0A5, 3'b111},
        {OP_RT, 9'h000, 9'h0A5, 3'b110},
        {OP_RD, 9'h000, 9'h101, 3'b110},
        {OP_RD, 9'h000, 9'h0A5, 3'b111},
        {OP_WR, 9'h0F0, 9'h0A5, 3'b110},
        {OP_WR, 9'h00F, 9'h0A5, 3'b110},
        {OP_WR, 9'h111, 9'h0A5, 3'b110},
        {OP_WR, 9'h122, 9'h0A5, 3'b100},
        {OP_WR, 9'h133, 9'h0A5, 3'b100},
        {OP_RD, 9'h000, 9'h1FF, 3'b110},
        {OP_RD, 9'h000, 9'h003, 3'b110},
        {OP_RD, 9'h000, 9'h044, 3'b110},
        {OP_RD, 9'h000, 9'h155, 3'b111},
        {OP_RD, 9'h000, 9'h0F0, 3'b111},
        {OP_RD, 9'h000, 9'h00F, 3'b111},
        {OP_RD, 9'h000, 9'h111, 3'b111},
        {OP_RD, 9'h000, 9'h122, 3'b011},
        {OP_RD, 9'h000, 9'h122, 3'b011}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       expand_mode = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       rexmit_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       full_n;
    logic       empty_n;
    logic       half_n;

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    strobed_fifo #(.DEPTH(DEPTH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .expand_mode (expand_mode),
        .wr_n        (wr_n),
        .rd_n        (rd_n),
        .rexmit_n    (rexmit_n),
        .din         (din),
        .dout        (dout),
        .full_n      (full_n),
        .empty_n     (empty_n),
        .half_n      (half_n)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag, input logic [2:0] exp);
        check({"R5 empty_n ", tag}, {8'd0, empty_n}, {8'd0, exp[2]});
        check({"R4 full_n ", tag},  {8'd0, full_n},  {8'd0, exp[1]});
        check({"R6 half_n ", tag},  {8'd0, half_n},  {8'd0, exp[0]});
    endtask

    task automatic do_write(input logic [8:0] d, input int hold);
        @(negedge clk);
        din  = d;
        wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_read(input int hold);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        rd_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_rexmit();
        @(negedge clk);
        rexmit_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        rexmit_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic apply_reset(input logic mode);
        @(negedge clk);
        rst_n       = 1'b0;
        expand_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 dout after reset", dout, 9'h000);
        check_flags("R1 after reset", 3'b011);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            string       tag;
            v = VEC[i];
            case (v[22:21])
                OP_WR:   begin do_write(v[20:12], SETTLE); tag = "R2/R11 write"; end
                OP_RD:   begin do_read(SETTLE);            tag = "R3 read"; end
                default: begin do_rexmit();                tag = "R7 retransmit"; end
            endcase
            check($sformatf("%s dout vec%0d", tag, i), dout, v[11:3]);
            check_flags($sformatf("vec%0d", i), v[2:0]);
        end

        // R10: write effect appears on the third clock edge, not the second
        @(negedge clk);
        din  = 9'h0AA;
        wr_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 empty_n before third edge", {8'd0, empty_n}, 9'd0);
        @(negedge clk);
        check("R10 empty_n after third edge", {8'd0, empty_n}, 9'd1);
        repeat (SETTLE) @(negedge clk);
        do_read(SETTLE);
        check("R10 latency word", dout, 9'h0AA);

        // R10: long pulses count once each
        do_write(9'h0B1, 30);
        do_write(9'h0B2, 30);
        do_read(30);
        check("R10 long read first", dout, 9'h0B1);
        do_read(30);
        check("R10 long read second", dout, 9'h0B2);
        check("R10 empty after two", {8'd0, empty_n}, 9'd0);
        do_read(SETTLE);
        check("R3 read on empty keeps dout", dout, 9'h0B2);

        // R4/R5: flag edges inside strobe pulses
        for (int k = 0; k < DEPTH - 1; k++) do_write(9'(16 + k), SETTLE);
        check("R6 half_n at seven", {8'd0, half_n}, 9'd0);
        @(negedge clk);
        din  = 9'h017;
        wr_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R4 full_n low while last write strobe low", {8'd0, full_n}, 9'd0);
        wr_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R4 full_n after last write", {8'd0, full_n}, 9'd0);
        do_write(9'h1EE, SETTLE);
        check("R2 write while full ignored, full_n", {8'd0, full_n}, 9'd0);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R4 full_n still low while read strobe low", {8'd0, full_n}, 9'd0);
        check("R3 read from full", dout, 9'h010);
        rd_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R4 full_n high after read rises", {8'd0, full_n}, 9'd1);
        for (int k = 1; k < DEPTH - 1; k++) do_read(SETTLE);
        check("R3 drain order", dout, 9'h016);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R5 empty_n low while last read strobe low", {8'd0, empty_n}, 9'd0);
        check("R2 dropped write left last word", dout, 9'h017);
        rd_n = 1'b1;
        repeat (SETTLE) @(negedge clk);

        // R9: flow-through into an empty queue
        do_write(9'h0C3, SETTLE);
        check("R9 empty_n after write", {8'd0, empty_n}, 9'd1);
        do_read(SETTLE);
        check("R9 flow-through word", dout, 9'h0C3);
        check("R9 empty_n after read", {8'd0, empty_n}, 9'd0);

        // R8: chained mode ignores retransmit and half-full
        apply_reset(1'b1);
        for (int k = 0; k < 6; k++) do_write(9'(32 + k), SETTLE);
        check("R8 half_n held high", {8'd0, half_n}, 9'd1);
        do_read(SETTLE);
        check("R8 first read", dout, 9'h020);
        do_rexmit();
        check("R8 retransmit leaves dout", dout, 9'h020);
        do_read(SETTLE);
        check("R8 retransmit ignored", dout, 9'h021);
        for (int k = 0; k < 4; k++) do_write(9'(48 + k), SETTLE);
        check("R8 full_n works in chained mode", {8'd0, full_n}, 9'd0);
        check("R8 half_n high when full", {8'd0, half_n}, 9'd1);

        // R1: reset during operation
        apply_reset(1'b0);
        check("R1 dout after mid reset", dout, 9'h000);
        check_flags("R1 after mid reset", 3'b011);
        do_read(SETTLE);
        check("R3 read after reset ignored", dout, 9'h000);

        finish_run();
    end
endmodule